// File: doc/BRIEF.md
# Add/Reverse-Subtract ALU with Carry Control

This block is the combinational integer adder of a small RISC execution stage. Each cycle it takes a 6-bit opcode, two register operands, an immediate, the low function field of the instruction word and the current value of the carry flag. From these it returns a result, the adder carry-out, and a flag that says whether the carry register should take that carry-out. The carry register itself lives outside the block.

The opcode group 0x00 to 0x0F is split into four independent control bits:

| Bit | Effect when set |
|-----|-----------------|
| 0 | Reverse subtraction (second operand minus first) |
| 1 | The stored carry is the carry-in |
| 2 | The carry flag is left unchanged |
| 3 | The immediate replaces register B |

Opcode 0x05 also carries two compare forms, chosen by the function field. These patch the top bit of the difference, so that bit gives the ordering of the two operands.

Top module: `addsub_alu`

## Requirements
- R1: When opcode bit 0 is 0, result_o equals A + X + cin, truncated to WIDTH bits. A is ra_i, X is the second operand and cin is the carry-in.
- R2: When opcode bit 0 is 1, result_o equals X + ~A + cin, truncated to WIDTH bits. This is X minus A when cin is 1.
- R3: When opcode bit 1 is 1, cin is carry_i. When opcode bit 1 is 0, cin is 0 for addition and 1 for reverse subtraction.
- R4: carry_o is bit WIDTH (the bit just above the result) of the full-width sum for the same operands and cin.
- R5: For opcodes 0x00 to 0x0F, carry_we_o is 1 exactly when opcode bit 2 is 0.
- R6: When opcode bit 3 is 1, X is imm_i and rb_i has no effect on any output. When opcode bit 3 is 0, X is rb_i.
- R7: For opcode 0x05 with func_i equal to 1 (signed compare), the low WIDTH-1 bits of result_o are those of rb_i - ra_i. The top bit is 1 exactly when rb_i < ra_i as signed numbers.
- R8: For opcode 0x05 with func_i equal to 3 (unsigned compare), the low WIDTH-1 bits of result_o are those of rb_i - ra_i. The top bit is 1 exactly when rb_i < ra_i as unsigned numbers.
- R9: The compare forms never assert carry_we_o. Opcode 0x05 with any other func_i value behaves as plain reverse subtraction.
- R10: For an opcode with bit 4 or bit 5 set, result_o, carry_o and carry_we_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Major opcode |
| func_i | input | FUNC_W | Low function field of the instruction word |
| ra_i | input | WIDTH | First register operand (A) |
| rb_i | input | WIDTH | Second register operand |
| imm_i | input | WIDTH | Sign-extended immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | WIDTH | Sum, difference or compare word |
| carry_o | output | 1 | Adder carry-out |
| carry_we_o | output | 1 | Write enable for the carry flag |

## Verification
The bench builds the block with WIDTH = 32 and FUNC_W = 11, the shape of a full instruction word. At this width the top-bit patch of both compare forms is exercised at its natural position. The carry out of bit 31 is also exercised with all-ones and sign-boundary operands. The expected values come from 64-bit integer arithmetic and from the signed and unsigned ordering of the operands, not from the bitwise formulas.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int OP_W = 6;

  typedef struct packed {
    logic in_grp;   // opcode within 0x00..0x0F
    logic rev;      // reverse subtract
    logic use_c;    // stored carry as carry-in
    logic keep;     // leave carry flag alone
    logic use_imm;  // immediate replaces rb
    logic cmp;      // compare form
    logic cmp_uns;  // unsigned compare
  } addsub_ctl_t;

  localparam logic [OP_W-1:0] OP_RSUBK  = 6'h05;
  localparam int              FN_CMP_S  = 1;
  localparam int              FN_CMP_U  = 3;
endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
#(
  parameter int FUNC_W = 11
) (
  input  logic [OP_W-1:0]   op,
  input  logic [FUNC_W-1:0] func,
  output addsub_ctl_t       ctl
);
  logic func_s, func_u;

  assign func_s = (func == FUNC_W'(FN_CMP_S));
  assign func_u = (func == FUNC_W'(FN_CMP_U));

  always_comb begin
    ctl         = '0;
    ctl.in_grp  = (op[5:4] == 2'b00);
    ctl.rev     = op[0];
    ctl.use_c   = op[1];
    ctl.keep    = op[2];
    ctl.use_imm = op[3];
    ctl.cmp     = (op == OP_RSUBK) && (func_s || func_u);
    ctl.cmp_uns = (op == OP_RSUBK) && func_u;
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] x,
  input  logic             rev,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int EXT_W = WIDTH + 1;

  function automatic logic [EXT_W-1:0] full_add(
    input logic [WIDTH-1:0] p,
    input logic [WIDTH-1:0] q,
    input logic             c
  );
    return {1'b0, p} + {1'b0, q} + {{WIDTH{1'b0}}, c};
  endfunction

  logic [WIDTH-1:0] a_eff;
  logic [EXT_W-1:0] wide;

  assign a_eff = rev ? ~a : a;
  assign wide  = full_add(x, a_eff, cin);
  assign sum   = wide[WIDTH-1:0];
  assign cout  = wide[WIDTH];
endmodule

// File: rtl/addsub_cmpfix.sv
module addsub_cmpfix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] diff,
  input  logic             a_msb,
  input  logic             b_msb,
  input  logic             en,
  input  logic             uns,
  output logic [WIDTH-1:0] res
);
  logic sign_diff, new_msb;

  assign sign_diff = a_msb ^ b_msb;
  assign new_msb   = uns ? a_msb : b_msb;

  always_comb begin
    res = diff;
    if (en && sign_diff) res[WIDTH-1] = new_msb;
  end
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import addsub_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int FUNC_W = 11
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [WIDTH-1:0]  ra_i,
  input  logic [WIDTH-1:0]  rb_i,
  input  logic [WIDTH-1:0]  imm_i,
  input  logic              carry_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_o,
  output logic              carry_we_o
);
  localparam int MSB = WIDTH - 1;

  addsub_ctl_t      ctl;
  logic [WIDTH-1:0] opnd_x;
  logic             cin_sel;
  logic [WIDTH-1:0] sum_raw;
  logic             cout_raw;
  logic [WIDTH-1:0] sum_fix;

  addsub_decode #(.FUNC_W(FUNC_W)) u_dec (
    .op(op_i), .func(func_i), .ctl(ctl)
  );

  assign opnd_x  = ctl.use_imm ? imm_i : rb_i;
  assign cin_sel = ctl.use_c ? carry_i : ctl.rev;

  addsub_core #(.WIDTH(WIDTH)) u_core (
    .a(ra_i), .x(opnd_x), .rev(ctl.rev), .cin(cin_sel),
    .sum(sum_raw), .cout(cout_raw)
  );

  addsub_cmpfix #(.WIDTH(WIDTH)) u_fix (
    .diff(sum_raw), .a_msb(ra_i[MSB]), .b_msb(opnd_x[MSB]),
    .en(ctl.cmp), .uns(ctl.cmp_uns), .res(sum_fix)
  );

  assign result_o   = ctl.in_grp ? sum_fix : '0;
  assign carry_o    = ctl.in_grp & cout_raw;
  assign carry_we_o = ctl.in_grp & ~ctl.keep & ~ctl.cmp;
endmodule

// File: rtl/addsub_alu_chk.sv
module addsub_alu_chk
  import addsub_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int FUNC_W = 11
) (
  input logic [OP_W-1:0]   op_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [WIDTH-1:0]  ra_i,
  input logic [WIDTH-1:0]  rb_i,
  input logic [WIDTH-1:0]  imm_i,
  input logic              carry_i,
  input logic [WIDTH-1:0]  result_o,
  input logic              carry_o,
  input logic              carry_we_o
);
  logic is_cmp;
  logic [WIDTH-1:0] bma;

  assign is_cmp = (op_i == OP_RSUBK) &&
                  (func_i == FUNC_W'(FN_CMP_S) || func_i == FUNC_W'(FN_CMP_U));
  assign bma    = rb_i - ra_i;

  always_comb begin
    // R5
    keep_blocks_we_chk: assert (!(carry_we_o && op_i[2]));
    // R10
    out_of_group_quiet_chk: assert (op_i[5:4] == 2'b00 ||
                                     (result_o == '0 && !carry_o && !carry_we_o));
    // R9
    cmp_no_we_chk: assert (!(is_cmp && carry_we_o));
    // R7
    cmp_low_bits_chk: assert (!is_cmp ||
                              result_o[WIDTH-2:0] == bma[WIDTH-2:0]);
    // R2
    rsub_plain_chk: assert (!(op_i == 6'h01) || result_o == bma);
  end
endmodule

bind addsub_alu addsub_alu_chk #(.WIDTH(WIDTH), .FUNC_W(FUNC_W)) u_chk (.*);

// File: tb/addsub_alu_tb.sv
module addsub_alu_tb;
  localparam int W  = 32;
  localparam int FW = 11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]    op;
  logic [FW-1:0] func;
  logic [W-1:0]  ra, rb, imm;
  logic          cin;
  logic [W-1:0]  res;
  logic          cout, we;

  int checks = 0;
  int fails  = 0;

  addsub_alu #(.WIDTH(W), .FUNC_W(FW)) u_dut (
    .op_i(op), .func_i(func), .ra_i(ra), .rb_i(rb), .imm_i(imm),
    .carry_i(cin), .result_o(res), .carry_o(cout), .carry_we_o(we)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] o, input int f, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] i, input logic c);
    @(negedge clk);
    op = o; func = FW'(f); ra = a; rb = b; imm = i; cin = c;
    #1;
  endtask

  // Arithmetic model built on 64-bit integer math
  task automatic run_arith(input string tag, input logic [5:0] o, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] i, input logic c);
    longint unsigned x, av, full, ci;
    drive(o, 0, a, b, i, c);
    x  = o[3] ? longint'(i) : longint'(b);
    av = longint'(a);
    ci = o[1] ? longint'(c) : (o[0] ? 1 : 0);
    if (o[0]) full = x + (64'h0_FFFF_FFFF - av) + ci;
    else      full = x + av + ci;
    chk({tag, " result"}, 64'(res), full & 64'hFFFF_FFFF);
    chk({tag, " carry"}, 64'(cout), (full >> 32) & 1);
    chk({tag, " we (R5)"}, 64'(we), 64'(!o[2]));
  endtask

  task automatic run_cmp(input string tag, input bit uns, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    logic [W-1:0] d;
    bit lt;
    drive(6'h05, uns ? 3 : 1, a, b, 32'h0, 1'b1);
    d  = b - a;
    lt = uns ? (b < a) : ($signed(b) < $signed(a));
    chk({tag, " low bits"}, 64'(res[W-2:0]), 64'(d[W-2:0]));
    chk({tag, " msb"}, 64'(res[W-1]), 64'(lt));
    chk({tag, " we (R9)"}, 64'(we), 0);
  endtask

  task automatic t_idle;
    drive(6'h30, 0, 32'h1234, 32'h5678, 32'h9, 1'b1);
    chk("R10 idle result", 64'(res), 0);
    chk("R10 idle carry", 64'(cout), 0);
    chk("R10 idle we", 64'(we), 0);
    drive(6'h10, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b1);
    chk("R10 op 0x10 result", 64'(res), 0);
    chk("R10 op 0x10 carry", 64'(cout), 0);
    chk("R10 op 0x10 we", 64'(we), 0);
  endtask

  task automatic t_add;
    run_arith("R1 add", 6'h00, 32'h0000_0005, 32'h0000_0007, 32'h0, 1'b1);
    run_arith("R1 R4 add wrap", 6'h00, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 1'b0);
    run_arith("R1 R4 addk", 6'h04, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0);
  endtask

  task automatic t_rsub;
    run_arith("R2 rsub", 6'h01, 32'h0000_0003, 32'h0000_000A, 32'h0, 1'b0);
    run_arith("R2 R4 rsub borrow", 6'h01, 32'h0000_000A, 32'h0000_0003, 32'h0, 1'b0);
    run_arith("R2 rsub equal", 6'h01, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 1'b0);
  endtask

  task automatic t_carry_in;
    run_arith("R3 addc c1", 6'h02, 32'h0000_0010, 32'h0000_0020, 32'h0, 1'b1);
    run_arith("R3 addc c0", 6'h02, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 1'b0);
    run_arith("R3 R4 addc ripple", 6'h02, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 1'b1);
    run_arith("R3 rsubc c0", 6'h03, 32'h0000_0004, 32'h0000_0009, 32'h0, 1'b0);
    run_arith("R3 rsubkc c1", 6'h07, 32'h0000_0004, 32'h0000_0009, 32'h0, 1'b1);
    run_arith("R3 add ignores carry", 6'h00, 32'h1, 32'h1, 32'h0, 1'b1);
  endtask

  task automatic t_keep;
    for (int o = 0; o < 16; o++)
      if (o != 5) run_arith("R5 keep sweep", 6'(o), 32'hA5A5_0001, 32'h5A5A_FFFF, 32'h0000_0F0F, 1'b1);
  endtask

  task automatic t_imm;
    run_arith("R6 addi", 6'h08, 32'h0000_0100, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0);
    run_arith("R6 rsubi", 6'h09, 32'h0000_0001, 32'hDEAD_BEEF, 32'h0000_0000, 1'b0);
    run_arith("R6 addikc", 6'h0E, 32'h0000_0100, 32'h1111_1111, 32'h0000_0200, 1'b1);
    drive(6'h0C, 0, 32'h0000_0100, 32'h0000_0000, 32'h0000_0022, 1'b0);
    chk("R6 rb zero", 64'(res), 64'h122);
    drive(6'h0C, 0, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0000_0022, 1'b0);
    chk("R6 rb ones", 64'(res), 64'h122);
  endtask

  task automatic t_cmp;
    run_cmp("R7 s pos<pos", 1'b0, 32'h0000_0010, 32'h0000_0004);
    run_cmp("R7 s neg<pos", 1'b0, 32'h0000_0001, 32'hFFFF_FFF0);
    run_cmp("R7 s pos>neg", 1'b0, 32'h8000_0000, 32'h7FFF_FFFF);
    run_cmp("R7 s equal", 1'b0, 32'h8000_0000, 32'h8000_0000);
    run_cmp("R8 u small<big", 1'b1, 32'hFFFF_FFF0, 32'h0000_0001);
    run_cmp("R8 u big>small", 1'b1, 32'h0000_0001, 32'h8000_0000);
    run_cmp("R8 u pos<pos", 1'b1, 32'h0000_0010, 32'h0000_0004);
  endtask

  task automatic t_other_func;
    drive(6'h05, 2, 32'h0000_0001, 32'hFFFF_FFF0, 32'h0, 1'b0);
    chk("R9 func2 plain result", 64'(res), 64'hFFFF_FFEF);
    chk("R9 func2 carry", 64'(cout), 1);
    chk("R9 func2 we", 64'(we), 0);
    drive(6'h05, 0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 1'b0);
    chk("R9 func0 plain result", 64'(res), 64'hFFFF_FFFF);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    op = 6'h3F; func = '0; ra = '0; rb = '0; imm = '0; cin = 1'b0;
    t_idle();
    t_add();
    t_rsub();
    t_carry_in();
    t_keep();
    t_imm();
    t_cmp();
    t_other_func();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule